// File: doc/BRIEF.md
# Sequential Channel Power-On Arbiter

This block turns on a group of line drivers one at a time. Each channel has a level request input: high asks for the driver to be on, and low asks for it to be off. When the sequencer is enabled, a raised request is stored first. Stored requests are then granted one by one. A grant is complete only when the granted channel has come out of its turn-on current limit. Only one capacitive load charges at any moment, so the inrush heating never adds up across channels.

When several requests are waiting, the lowest channel number wins, whatever order they arrived in. A request that goes low takes effect at once and does not pass through the queue. A thermal gate input stops new requests from entering the store, but requests already stored are still served. A strap input bypasses the sequencer, and then every driver simply follows its request. The block is clocked from a slow external clock, nominally 8 kHz. All of its timing is counted in clock cycles.

Top module: `chan_power_seq`

## Requirements
- R1: While `rst_n` is low, every bit of `drv_en` and `pof` is 0. After release, a channel whose request stays low is never enabled.
- R2: With the sequencer enabled (`seq_bypass`=0), no thermal hold and the channel off, a request that is high at a clock edge sets that channel's `pof` bit after that edge. Its `drv_en` bit is still 0 after that edge.
- R3: At most one channel is in power-up at any time, where power-up means its `drv_en` and `pof` bits are both 1.
- R4: While the channel in power-up reports `cur_lim`=1 at a clock edge, no other channel's `drv_en` rises at that edge.
- R5: With no channel in power-up, the edge after requests are stored enables the stored channel with the lowest index. Bit 0 is channel 0.
- R6: The `pof` bit of the channel in power-up falls at the first edge after its grant at which its `cur_lim` is 0. The next stored channel is enabled at the following edge. A `cur_lim` raised afterwards on a finished channel does not change the sequence.
- R7: A request that is low at an edge clears that channel's `drv_en` and `pof` at that edge. This holds whether the channel is enabled, in power-up or only stored, and a stored request removed this way is never granted.
- R8: If the channel in power-up keeps `cur_lim` high, no further channel is enabled until that channel's request goes low. At the edge after that, the next stored channel is enabled.
- R9: While `therm_hold`=1, a request not yet stored is not stored and not enabled. Requests already stored are still granted in order. After `therm_hold` returns to 0, a request that is still high is stored at the next edge.
- R10: With `seq_bypass`=1, each `drv_en` bit equals its `act_req` bit sampled at the previous edge, and `pof` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_bypass | input | 1 | Strap: 1 turns the sequencer off, so drivers follow requests directly |
| therm_hold | input | 1 | Thermal gate: 1 blocks new requests from entering the store |
| act_req | input | N_CH | Per-channel activation request level (1 = on) |
| cur_lim | input | N_CH | Per-channel current-limit flag (1 = limiting) |
| drv_en | output | N_CH | Per-channel line-driver enable |
| pof | output | N_CH | Per-channel power-on flag: stored or in power-up |

## Verification
The bench applies every non-empty set of simultaneous requests on four channels. For each set, it computes the expected grant order by repeatedly taking the lowest set bit. It holds each current limit for several cycles before releasing it and then re-raises it on the finished channel. A design that served requests in arrival order or highest-first would enable the wrong channel, one that granted early would show two channels in power-up, and one that re-entered power-up on a later limit would stall the sequence. Directed sequences cover the remaining cases:
- a pending request withdrawn before its grant, which a faulty design would still power up;
- a permanently limited channel that must block the queue until it is switched off;
- the thermal gate, which must block new entries without starving stored ones;
- the bypass strap;
- a reset taken in the middle of a sequence.

// File: rtl/cps_pkg.sv
package cps_pkg;
   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RAMP = 1'b1
   } seq_state_e;

   localparam int unsigned CPS_MAX_CH = 32;
endpackage

// File: rtl/cps_req_store.sv
module cps_req_store #(
   parameter int unsigned N_CH = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            seq_bypass,
   input  logic            therm_hold,
   input  logic [N_CH-1:0] act_req,
   input  logic [N_CH-1:0] drv_en,
   input  logic [N_CH-1:0] take,
   output logic [N_CH-1:0] pend
);
   logic [N_CH-1:0] pend_q;
   logic [N_CH-1:0] pend_d;

   for (genvar g = 0; g < N_CH; g++) begin : g_slot
      logic admit;
      assign admit     = !drv_en[g] && !therm_hold;
      assign pend_d[g] = !seq_bypass && act_req[g] && !take[g] &&
                         (pend_q[g] || admit);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_d;
   end

   assign pend = pend_q;
endmodule

// File: rtl/cps_prio_pick.sv
module cps_prio_pick #(
   parameter int unsigned N_CH = 4
) (
   input  logic [N_CH-1:0] req,
   output logic [N_CH-1:0] gnt,
   output logic            any
);
   logic [N_CH:0] seen;

   assign seen[0] = 1'b0;
   for (genvar g = 0; g < N_CH; g++) begin : g_chain
      assign gnt[g]    = req[g] && !seen[g];
      assign seen[g+1] = seen[g] || req[g];
   end

   assign any = seen[N_CH];
endmodule

// File: rtl/cps_drv_ctrl.sv
module cps_drv_ctrl
   import cps_pkg::*;
#(
   parameter int unsigned N_CH = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            seq_bypass,
   input  logic [N_CH-1:0] act_req,
   input  logic [N_CH-1:0] cur_lim,
   input  logic [N_CH-1:0] gnt_oh,
   output logic [N_CH-1:0] take,
   output logic [N_CH-1:0] drv_en,
   output logic [N_CH-1:0] ramp_oh
);
   seq_state_e      state_q, state_d;
   logic [N_CH-1:0] act_oh_q, act_oh_d;
   logic [N_CH-1:0] en_q, en_d;
   logic            ramping, lim_hit, off_hit, fire;

   assign ramping = (state_q == SEQ_RAMP);
   assign lim_hit = |(act_oh_q & cur_lim);
   assign off_hit = |(act_oh_q & ~act_req);
   assign fire    = !ramping && !seq_bypass && |(gnt_oh & act_req);
   assign take    = fire ? gnt_oh : '0;

   always_comb begin
      state_d  = state_q;
      act_oh_d = act_oh_q;
      if (seq_bypass) begin
         state_d  = SEQ_IDLE;
         act_oh_d = '0;
      end else if (ramping) begin
         if (!lim_hit || off_hit) begin
            state_d  = SEQ_IDLE;
            act_oh_d = '0;
         end
      end else if (fire) begin
         state_d  = SEQ_RAMP;
         act_oh_d = gnt_oh;
      end
   end

   always_comb begin
      if (seq_bypass) en_d = act_req;
      else            en_d = (en_q | take) & act_req;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= SEQ_IDLE;
         act_oh_q <= '0;
         en_q     <= '0;
      end else begin
         state_q  <= state_d;
         act_oh_q <= act_oh_d;
         en_q     <= en_d;
      end
   end

   assign drv_en  = en_q;
   assign ramp_oh = ramping ? act_oh_q : '0;
endmodule

// File: rtl/chan_power_seq.sv
module chan_power_seq #(
   parameter int unsigned N_CH = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            seq_bypass,
   input  logic            therm_hold,
   input  logic [N_CH-1:0] act_req,
   input  logic [N_CH-1:0] cur_lim,
   output logic [N_CH-1:0] drv_en,
   output logic [N_CH-1:0] pof
);
   if (N_CH < 2 || N_CH > cps_pkg::CPS_MAX_CH) begin : g_bad_cfg
      $error("chan_power_seq: N_CH out of range");
   end

   logic [N_CH-1:0] pend, gnt_oh, take, ramp_oh;
   logic            gnt_any;

   cps_req_store #(.N_CH(N_CH)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .seq_bypass (seq_bypass),
      .therm_hold (therm_hold),
      .act_req    (act_req),
      .drv_en     (drv_en),
      .take       (take),
      .pend       (pend)
   );

   cps_prio_pick #(.N_CH(N_CH)) u_pick (
      .req (pend),
      .gnt (gnt_oh),
      .any (gnt_any)
   );

   cps_drv_ctrl #(.N_CH(N_CH)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .seq_bypass (seq_bypass),
      .act_req    (act_req),
      .cur_lim    (cur_lim),
      .gnt_oh     (gnt_any ? gnt_oh : '0),
      .take       (take),
      .drv_en     (drv_en),
      .ramp_oh    (ramp_oh)
   );

   assign pof = pend | ramp_oh;
endmodule

// File: rtl/cps_checker.sv
module cps_checker #(
   parameter int unsigned N_CH = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            seq_bypass,
   input logic            therm_hold,
   input logic [N_CH-1:0] act_req,
   input logic [N_CH-1:0] cur_lim,
   input logic [N_CH-1:0] drv_en,
   input logic [N_CH-1:0] pof
);
   logic past_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |-> (drv_en == '0 && pof == '0));

   // R3
   one_ramp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(drv_en & pof) <= 1);

   // R4
   no_grant_while_limited_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !seq_bypass && !$past(seq_bypass) &&
       ($past(drv_en & pof & cur_lim & act_req) != '0))
      |-> ((drv_en & ~$past(drv_en)) == '0));

   // R7
   off_at_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (((drv_en | pof) & ~$past(act_req)) == '0));

   // R10
   bypass_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && seq_bypass && $past(seq_bypass)) |-> (pof == '0));

   // R9
   hold_no_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(therm_hold) && !$past(seq_bypass))
      |-> ((pof & ~$past(pof)) == '0));
endmodule

bind chan_power_seq cps_checker #(.N_CH(N_CH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .seq_bypass (seq_bypass),
   .therm_hold (therm_hold),
   .act_req    (act_req),
   .cur_lim    (cur_lim),
   .drv_en     (drv_en),
   .pof        (pof)
);

// File: tb/tb_chan_power_seq.sv
module tb_chan_power_seq;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       seq_bypass = 1'b0;
   logic       therm_hold = 1'b0;
   logic [3:0] act_req = '0;
   logic [3:0] cur_lim = '0;
   logic [3:0] drv_en, pof;
   int         checks = 0;
   int         fails = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   chan_power_seq #(.N_CH(4)) dut (
      .clk(clk), .rst_n(rst_n), .seq_bypass(seq_bypass), .therm_hold(therm_hold),
      .act_req(act_req), .cur_lim(cur_lim), .drv_en(drv_en), .pof(pof)
   );

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic do_reset(logic byp);
      rst_n = 1'b0;
      act_req = '0; cur_lim = '0; therm_hold = 1'b0; seq_bypass = byp;
      tick(); tick();
      rst_n = 1'b1;
      tick();
   endtask

   initial begin
      rst_n = 1'b0;
      tick();
      chk("R1 drv_en in reset", drv_en, 4'b0000);
      chk("R1 pof in reset", pof, 4'b0000);
      do_reset(1'b0);

      // R5 R6 R4 R2 R3: every simultaneous request set
      for (int m = 1; m < 16; m++) begin
         logic [3:0] rem, en, low;
         do_reset(1'b0);
         cur_lim = 4'hF;
         act_req = 4'(m);
         tick();
         chk("R2 stored flag", pof, 4'(m));
         chk("R2 not yet enabled", drv_en, 4'b0000);
         tick();
         rem = 4'(m); en = '0;
         while (rem != 0) begin
            low = rem & (~rem + 4'd1);
            en  = en | low;
            chk("R5 lowest first", drv_en, en);
            chk("R3 single ramp flags", pof, rem);
            repeat (3) tick();
            chk("R4 wait on limit", drv_en, en);
            cur_lim = cur_lim & ~low;
            tick();
            rem = rem & ~low;
            chk("R6 flag falls", pof, rem);
            cur_lim = cur_lim | low;
            tick();
         end
         chk("R6 later limit ignored", drv_en, 4'(m));
         chk("R6 flags clear", pof, 4'b0000);
      end

      // R7: withdraw a stored request and a running channel
      do_reset(1'b0);
      cur_lim = 4'hF; act_req = 4'b0101;
      tick(); tick();
      chk("R7 setup", drv_en, 4'b0001);
      act_req = 4'b0001;
      tick();
      chk("R7 stored removed", pof, 4'b0001);
      cur_lim = 4'b1110;
      tick(); tick(); tick();
      chk("R7 removed never granted", drv_en, 4'b0001);
      chk("R7 no flag", pof, 4'b0000);
      act_req = 4'b0000;
      tick();
      chk("R7 driver off", drv_en, 4'b0000);

      // R8: permanently limited channel blocks the queue
      do_reset(1'b0);
      cur_lim = 4'hF; act_req = 4'b1010;
      tick(); tick();
      repeat (20) tick();
      chk("R8 blocked", drv_en, 4'b0010);
      act_req = 4'b1000;
      tick();
      chk("R8 off releases", drv_en, 4'b0000);
      chk("R8 remaining flag", pof, 4'b1000);
      tick();
      chk("R8 next granted", drv_en, 4'b1000);

      // R1: reset mid-sequence
      rst_n = 1'b0;
      tick();
      chk("R1 mid reset drv", drv_en, 4'b0000);
      chk("R1 mid reset pof", pof, 4'b0000);
      act_req = 4'b0000;
      rst_n = 1'b1;
      tick(); tick(); tick();
      chk("R1 nothing after reset", drv_en | pof, 4'b0000);

      // R9: thermal gate
      do_reset(1'b0);
      cur_lim = 4'hF; act_req = 4'b0011;
      tick();
      therm_hold = 1'b1; act_req = 4'b0111;
      tick();
      chk("R9 new rejected", pof, 4'b0011);
      chk("R9 first granted", drv_en, 4'b0001);
      tick(); tick();
      chk("R9 still rejected", pof, 4'b0011);
      cur_lim = 4'b1110;
      tick();
      chk("R9 ramp done", pof, 4'b0010);
      tick();
      chk("R9 stored served", drv_en, 4'b0011);
      therm_hold = 1'b0;
      tick();
      chk("R9 stored after release", pof, 4'b0110);

      // R10: bypass strap
      do_reset(1'b1);
      cur_lim = 4'hF; act_req = 4'b0101;
      tick();
      chk("R10 follows", drv_en, 4'b0101);
      chk("R10 no flag", pof, 4'b0000);
      act_req = 4'b1100;
      tick();
      chk("R10 follows change", drv_en, 4'b1100);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule